// File: doc/BRIEF.md
# Closed-Loop Rate-Nulling Phase Loop

This block closes the digital feedback loop of an interferometric rotation sensor. It takes one signed 16-bit detector sample per clock. Each sample is demodulated against a square-wave bias whose full period equals the coil transit time. The demodulated error is smoothed by a moving average over the last eight samples. Once per transit period, an integral controller adds the smoothed error to a saturating accumulator. The accumulator value is the step size of a staircase feedback ramp.

The ramp is a 16-bit phase register in which 2π maps to full scale, so it wraps naturally. On every clock the ramp is summed with the bias offset to form the modulator DAC code. The bias offset equals a quarter of full scale, which is π/2.

A host reads the loop's rate estimate through a synchronization pulse. The pulse input is resynchronized and edge-detected. The integrator value is then captured and held with a valid flag until the next pulse.

Top module: `rate_null_loop`

## Requirements
- R1: A synchronous reset held for at least two clock edges leaves `dacCode` = 16384, `hostRate` = 0 and `hostValid` = 0. It also clears the filter, integrator, ramp and bias phase.
- R2: After reset the bias starts in its positive half. Each half lasts `HALF_CYC` clocks (8 by default). During the positive half, 16384 is added to the ramp to form `dacCode`. During the negative half, 0 is added. The sum is taken modulo 2^16.
- R3: A sample is demodulated as +sample in the positive half and −sample in the negative half, using the half in force on the clock edge that takes it.
- R4: The filtered error is the sum of the last eight demodulated values, arithmetically shifted right by three (floor). Slots not yet written since reset count as zero.
- R5: The integrator changes only on the final clock of the negative half. On that clock it adds the filtered error that was present before that edge.
- R6: The integrator is a signed 24-bit value that saturates at 8388607 and at −8388608 rather than wrapping.
- R7: On the same clock as R5, the ramp advances by the low 16 bits of the integrator value from before the update. The ramp wraps modulo 2^16 and is constant at all other times.
- R8: `syncIn` passes through two flops and is edge-detected. On the third rising clock edge after it is first sampled high, the integrator value from before that edge is copied to `hostRate` and `hostValid` is set. Both then hold until the next capture.
- R9: A level held high on `syncIn` causes only one capture. Another capture needs a low-to-high transition.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sampleIn | input | 16 | Signed detector sample, one per clock |
| syncIn | input | 1 | Asynchronous host synchronization pulse |
| dacCode | output | 16 | Ramp plus bias, unsigned code for the modulator DAC |
| hostRate | output | 24 | Captured signed integrator value |
| hostValid | output | 1 | Set after the first capture since reset |

## Verification
A corrupted bias phase counter shows up in `dacCode` on the next clock. It appears as a misplaced 16384 step, and the ramp then starts stepping on the wrong clock. A wrong filter tap, running sum or demodulation sign stays hidden in the ramp until the next period boundary. The integrator is exposed only through the step size it adds to the ramp at period ends, or through `hostRate` after a pulse. Its errors therefore show up no later than two transit periods after they occur. The bench follows a cycle-by-cycle model, so any departure at either output is reported in the clock where it first appears.

// File: rtl/rnl_pkg.sv
package rnl_pkg;
  // strobes from the bias timing control to the datapath
  typedef struct packed {
    logic negHalf;    // bias in its negative half
    logic periodEnd;  // last clock of the transit period
    logic capture;    // synchronized rising edge of the host pulse
  } strobe_t;
endpackage

// File: rtl/rnl_ctrl.sv
module rnl_ctrl
  import rnl_pkg::*;
#(
  parameter int HALF_CYC = 8
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    syncIn,
  output strobe_t strb
);
  localparam int CNT_W = $clog2(HALF_CYC + 1);

  logic [CNT_W-1:0] halfCnt;
  logic             phase;
  logic [2:0]       syncPipe;
  logic             lastCyc;

  assign lastCyc = (halfCnt == CNT_W'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      halfCnt  <= '0;
      phase    <= 1'b0;
      syncPipe <= '0;
    end else begin
      if (lastCyc) begin
        halfCnt <= '0;
        phase   <= ~phase;
      end else begin
        halfCnt <= halfCnt + 1'b1;
      end
      syncPipe <= {syncPipe[1:0], syncIn};
    end
  end

  always_comb begin
    strb.negHalf   = phase;
    strb.periodEnd = phase & lastCyc;
    strb.capture   = syncPipe[1] & ~syncPipe[2];
  end
endmodule

// File: rtl/rnl_datapath.sv
module rnl_datapath
  import rnl_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int AVG_LOG2 = 3,
  parameter int INT_W    = 24,
  parameter int DAC_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    strb,
  input  logic [SAMPLE_W-1:0]        sampleIn,
  output logic [DAC_W-1:0]           dacCode,
  output logic [INT_W-1:0]           hostRate,
  output logic                       hostValid,
  output logic [INT_W-1:0]           integVal,
  output logic [SAMPLE_W:0]          avgVal
);
  localparam int DEMOD_W   = SAMPLE_W + 1;
  localparam int SUM_W     = DEMOD_W + AVG_LOG2;
  localparam int AVG_DEPTH = 1 << AVG_LOG2;
  localparam logic [DAC_W-1:0] BIAS = {2'b01, {(DAC_W-2){1'b0}}};
  localparam logic signed [INT_W:0] INT_MAX = {2'b00, {(INT_W-1){1'b1}}};
  localparam logic signed [INT_W:0] INT_MIN = {2'b11, {(INT_W-1){1'b0}}};

  logic signed [DEMOD_W-1:0] sampleExt, demod;
  logic signed [DEMOD_W-1:0] taps [AVG_DEPTH];
  logic [AVG_LOG2-1:0]       wrPtr;
  logic signed [SUM_W-1:0]   runSum, sumNext, sumShift;
  logic signed [INT_W-1:0]   integ;
  logic signed [INT_W:0]     integSum, integNext;
  logic [DAC_W-1:0]          ramp;

  // demodulation: sign follows the bias half
  assign sampleExt = {sampleIn[SAMPLE_W-1], sampleIn};
  assign demod     = strb.negHalf ? -sampleExt : sampleExt;

  // moving average: circular buffer and running sum
  assign sumNext  = runSum + {{AVG_LOG2{demod[DEMOD_W-1]}}, demod}
                           - {{AVG_LOG2{taps[wrPtr][DEMOD_W-1]}}, taps[wrPtr]};
  assign sumShift = runSum >>> AVG_LOG2;
  assign avgVal   = sumShift[DEMOD_W-1:0];

  // integral controller with saturation
  assign integSum = {integ[INT_W-1], integ}
                  + {{(INT_W+1-DEMOD_W){avgVal[DEMOD_W-1]}}, avgVal};
  always_comb begin
    if (integSum[INT_W] != integSum[INT_W-1])
      integNext = integSum[INT_W] ? INT_MIN : INT_MAX;
    else
      integNext = integSum;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < AVG_DEPTH; i++) taps[i] <= '0;
      wrPtr     <= '0;
      runSum    <= '0;
      integ     <= '0;
      ramp      <= '0;
      hostRate  <= '0;
      hostValid <= 1'b0;
    end else begin
      taps[wrPtr] <= demod;
      wrPtr       <= wrPtr + 1'b1;
      runSum      <= sumNext;
      if (strb.periodEnd) begin
        ramp  <= ramp + integ[DAC_W-1:0];
        integ <= integNext[INT_W-1:0];
      end
      if (strb.capture) begin
        hostRate  <= integ;
        hostValid <= 1'b1;
      end
    end
  end

  assign integVal = integ;
  assign dacCode  = ramp + (strb.negHalf ? '0 : BIAS);
endmodule

// File: rtl/rate_null_loop.sv
module rate_null_loop
  import rnl_pkg::*;
#(
  parameter int HALF_CYC = 8,
  parameter int SAMPLE_W = 16,
  parameter int AVG_LOG2 = 3,
  parameter int INT_W    = 24,
  parameter int DAC_W    = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [SAMPLE_W-1:0] sampleIn,
  input  logic                syncIn,
  output logic [DAC_W-1:0]    dacCode,
  output logic [INT_W-1:0]    hostRate,
  output logic                hostValid
);
  localparam int DEMOD_W = SAMPLE_W + 1;

  strobe_t             strb;
  logic [INT_W-1:0]    integVal;
  logic [DEMOD_W-1:0]  avgVal;

  rnl_ctrl #(.HALF_CYC(HALF_CYC)) ctrl_i (
    .clk    (clk),
    .rst    (rst),
    .syncIn (syncIn),
    .strb   (strb)
  );

  rnl_datapath #(
    .SAMPLE_W(SAMPLE_W), .AVG_LOG2(AVG_LOG2), .INT_W(INT_W), .DAC_W(DAC_W)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .sampleIn  (sampleIn),
    .dacCode   (dacCode),
    .hostRate  (hostRate),
    .hostValid (hostValid),
    .integVal  (integVal),
    .avgVal    (avgVal)
  );
endmodule

// File: rtl/rate_null_loop_chk.sv
module rate_null_loop_chk
  import rnl_pkg::*;
#(
  parameter int INT_W   = 24,
  parameter int DEMOD_W = 17,
  parameter int DAC_W   = 16
) (
  input logic               clk,
  input logic               rst,
  input strobe_t            strb,
  input logic [INT_W-1:0]   integVal,
  input logic [DEMOD_W-1:0] avgVal,
  input logic [DAC_W-1:0]   dacCode,
  input logic [INT_W-1:0]   hostRate,
  input logic               hostValid
);
  localparam logic [DAC_W-1:0] BIAS     = {2'b01, {(DAC_W-2){1'b0}}};
  localparam logic [DAC_W-1:0] BIAS_NEG = ~BIAS + 1'b1;

  logic [DAC_W-1:0] prevDac, dacDiff;
  always_ff @(posedge clk) prevDac <= dacCode;
  assign dacDiff = dacCode - prevDac;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!hostValid && hostRate == '0));

  p_bias_only_step_r2: assert property (@(posedge clk) disable iff (rst)
    !strb.periodEnd |=> (dacDiff == '0 || dacDiff == BIAS || dacDiff == BIAS_NEG));

  p_period_in_neg_half_r5: assert property (@(posedge clk) disable iff (rst)
    strb.periodEnd |-> strb.negHalf);

  p_integ_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !strb.periodEnd |=> $stable(integVal));

  p_no_wrap_down_r6: assert property (@(posedge clk) disable iff (rst)
    (strb.periodEnd && !avgVal[DEMOD_W-1]) |=> $signed(integVal) >= $signed($past(integVal)));

  p_host_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !strb.capture |=> ($stable(hostRate) && $stable(hostValid)));
endmodule

bind rate_null_loop rate_null_loop_chk #(
  .INT_W(INT_W), .DEMOD_W(DEMOD_W), .DAC_W(DAC_W)
) chk_i (
  .clk       (clk),
  .rst       (rst),
  .strb      (strb),
  .integVal  (integVal),
  .avgVal    (avgVal),
  .dacCode   (dacCode),
  .hostRate  (hostRate),
  .hostValid (hostValid)
);

// File: tb/rate_null_loop_tb_top.sv
`timescale 1ns/1ps
module rate_null_loop_tb_top;
  localparam int HALF = 8;
  localparam int NVEC = 10;
  localparam int IMAX = 8388607;
  localparam int IMIN = -8388608;

  // stimulus table: sample value, clocks to hold it, sync level
  localparam int VSAMP [NVEC] = '{1000, 1000, 1000, -2500, -2500, 32767, -32768, 123, 0, 7};
  localparam int VLEN  [NVEC] = '{40, 6, 30, 50, 4, 20, 37, 10, 25, 9};
  localparam bit VSYNC [NVEC] = '{0, 1, 0, 0, 1, 0, 0, 1, 0, 1};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sampleIn = '0;
  logic        syncIn = 1'b0;
  logic [15:0] dacCode;
  logic [23:0] hostRate;
  logic        hostValid;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;
  bit finished = 0;

  // reference model state
  bit mPhase, mValid, s1, s2, s3;
  int mCnt, mInteg, mRamp, mHost;
  int hist [8];

  always #2.5 clk = ~clk;

  rate_null_loop dut_i (
    .clk(clk), .rst(rst), .sampleIn(sampleIn), .syncIn(syncIn),
    .dacCode(dacCode), .hostRate(hostRate), .hostValid(hostValid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      misses++;
      $display("FAIL watchdog expired after %0d cycles (expected completion)", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  function automatic int sat24(input int v);
    if (v > IMAX) return IMAX;
    if (v < IMIN) return IMIN;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compareAll();
    int expDac;
    expDac = (mRamp + (mPhase ? 0 : 16384)) & 65535;
    check(int'(dacCode) == expDac, "R2 R3 R4 R5 R7 dacCode", int'(dacCode), expDac);
    check(int'($signed(hostRate)) == mHost, "R5 R6 R8 R9 hostRate",
          int'($signed(hostRate)), mHost);
    check(hostValid == mValid, "R8 hostValid", int'(hostValid), int'(mValid));
  endtask

  task automatic modelClear();
    mPhase = 0; mValid = 0; s1 = 0; s2 = 0; s3 = 0;
    mCnt = 0; mInteg = 0; mRamp = 0; mHost = 0;
    for (int k = 0; k < 8; k++) hist[k] = 0;
  endtask

  task automatic doReset();
    rst = 1'b1;
    syncIn = 1'b0;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    modelClear();
    rst = 1'b0;
    // R1: state right after reset
    check(dacCode == 16'd16384, "R1 dacCode", int'(dacCode), 16384);
    check(hostRate == '0, "R1 hostRate", int'(hostRate), 0);
    check(hostValid == 1'b0, "R1 hostValid", int'(hostValid), 0);
  endtask

  // one clock: drive at the falling edge, advance the model, compare after the next rise
  task automatic step(input int s, input bit y);
    int d, acc, avgOld;
    bit pe, rise;
    sampleIn = 16'(s);
    syncIn   = y;
    d = mPhase ? -s : s;
    acc = 0;
    for (int k = 0; k < 8; k++) acc += hist[k];
    avgOld = acc >>> 3;
    pe   = mPhase && (mCnt == HALF - 1);
    rise = s2 && !s3;
    if (rise) begin mHost = mInteg; mValid = 1; end
    if (pe) begin
      mRamp  = (mRamp + (mInteg & 65535)) & 65535;
      mInteg = sat24(mInteg + avgOld);
    end
    for (int k = 7; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = d;
    s3 = s2; s2 = s1; s1 = y;
    if (mCnt == HALF - 1) begin mCnt = 0; mPhase = !mPhase; end
    else mCnt++;
    @(posedge clk);
    @(negedge clk);
    compareAll();
  endtask

  initial begin
    doReset();
    // table walk: R2 R3 R4 R5 R7 on every clock, R8 on pulses, R9 on the long-held level
    for (int i = 0; i < NVEC; i++)
      for (int c = 0; c < VLEN[i]; c++)
        step(VSAMP[i], VSYNC[i]);

    // R6: drive demodulated error to full positive scale until the integrator clamps
    for (int c = 0; c < 5000; c++) step(mPhase ? -32768 : 32767, 1'b0);
    for (int c = 0; c < 3; c++) step(0, 1'b1);
    for (int c = 0; c < 3; c++) step(0, 1'b0);
    check(int'($signed(hostRate)) == IMAX, "R6 positive clamp", int'($signed(hostRate)), IMAX);

    // R6: full negative scale
    for (int c = 0; c < 9000; c++) step(mPhase ? 32767 : -32768, 1'b0);
    for (int c = 0; c < 3; c++) step(0, 1'b1);
    for (int c = 0; c < 3; c++) step(0, 1'b0);
    check(int'($signed(hostRate)) == IMIN, "R6 negative clamp", int'($signed(hostRate)), IMIN);

    // R9: a long high level captures once; the value stays put while the loop moves
    for (int c = 0; c < 40; c++) step(5000, 1'b1);
    for (int c = 0; c < 20; c++) step(-700, 1'b0);

    // R1: reset in the middle of activity
    doReset();
    for (int c = 0; c < 48; c++) step(300, c < 5);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule